// File: doc/BRIEF.md
# Sequential-Append Sector Translation Engine

This block sits between a sector request stream and flash that accepts page programs only in ascending order inside each erase unit. Each virtual unit owns an ordered chain of physical units. A write for any sector offset goes to the next unused physical sector at the end of that chain. The offset is stored next to the data, so placement does not follow the virtual numbering. A read walks the chain from the most recent write back to the oldest and returns the first sector whose stored offset matches the request.

When the tail unit of a chain is full, or the chain is still empty, the write takes one unit from an external free-unit allocator. It links that unit to the chain and programs the unit's first sector in the same commit cycle. If no unit can be taken, the write is refused and no state changes. The allocator can be empty, or the chain can already hold its maximum number of units. Page storage is modelled by a small on-chip metadata memory that holds the offset and data of every physical sector.

The controller is a state machine with three states. ST_IDLE holds `ready` high and accepts a request, moving to ST_WRITE for writes and to ST_SCAN for reads. ST_WRITE commits or refuses the write in one cycle and returns to ST_IDLE. ST_SCAN examines one physical sector per cycle and stays in ST_SCAN until one of three things happens: a match, the oldest sector has been examined, or the chain is empty. It then returns to ST_IDLE. Every return to ST_IDLE raises `rsp_valid` for one cycle.

Top module: `seqapp_xlate`

## Requirements
- R1: After reset `ready` is 1, `rsp_valid` is 0, `alloc_take` is 0, and every virtual unit's chain is empty, so a read of any sector reports miss.
- R2: Successive accepted writes to one virtual unit land in physical sectors 0, 1, 2, … of the tail unit in that order, whatever offsets are requested, including a repeated offset.
- R3: Each written physical sector keeps the requested offset and data, so a later read of that offset returns status OK (code 0), the data, and the physical unit and sector where it was placed.
- R4: A write that finds the chain empty or its tail unit full pulses `alloc_take` for exactly one cycle, links `alloc_unit` as the new tail and reports sector 0 of that unit in the response that follows.
- R5: A write that needs a new unit while `alloc_valid` is 0 responds with status NOSPACE (code 2) and does not pulse `alloc_take`. It writes nothing, so the chain's fill position is unchanged.
- R6: A write that needs a new unit while the chain already holds MAX_CHAIN units responds with NOSPACE (code 2) and takes no unit.
- R7: When an offset has been written several times, a read returns the most recently written copy.
- R8: A read of an offset never written in that virtual unit responds with status MISS (code 1).
- R9: `rsp_valid` is high for exactly one cycle per accepted request, and `ready` is low from the cycle after acceptance until that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when `ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vu | input | VU_W | Virtual unit number |
| req_off | input | SEC_W | Sector offset inside the virtual unit |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Engine idle and able to accept a request |
| alloc_valid | input | 1 | Allocator holds at least one free unit |
| alloc_unit | input | PU_W | Free physical unit offered by the allocator |
| alloc_take | output | 1 | Offered unit consumed this cycle |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_status | output | 2 | 0 OK, 1 MISS, 2 NOSPACE |
| rsp_pu | output | PU_W | Physical unit written or found |
| rsp_sec | output | SEC_W | Physical sector written or found |
| rsp_rdata | output | DATA_W | Data found by a read |

## Verification
The bench writes the same offset twice and then reads it. A design that indexed placement by offset would overwrite sector 0, and a scan running oldest-first would return the stale copy. It fills a tail unit exactly to its last sector so the next write must extend the chain. A design off by one in the fill pointer would skip sector 0 or take a unit too early. It drains the allocator and saturates a chain to MAX_CHAIN. A design that updated its pointers before checking for space would report NOSPACE yet leave a hole, and the bench exposes that through the location of the next accepted write and through a read that must still miss.

// File: rtl/seqapp_pkg.sv
package seqapp_pkg;

    typedef enum logic [1:0] {
        RSP_OK      = 2'd0,
        RSP_MISS    = 2'd1,
        RSP_NOSPACE = 2'd2
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_SCAN  = 2'd2
    } state_e;

endpackage

// File: rtl/seqapp_meta_mem.sv
// Per-physical-sector record: stored virtual offset plus data.
module seqapp_meta_mem #(
    parameter int NUM_PU     = 8,
    parameter int SEC_PER_PU = 4,
    parameter int DATA_W     = 8
) (
    input  logic                              clk,
    input  logic                              we,
    input  logic [$clog2(NUM_PU)+$clog2(SEC_PER_PU)-1:0] waddr,
    input  logic [$clog2(SEC_PER_PU)-1:0]     woff,
    input  logic [DATA_W-1:0]                 wdat,
    input  logic [$clog2(NUM_PU)+$clog2(SEC_PER_PU)-1:0] raddr,
    output logic [$clog2(SEC_PER_PU)-1:0]     roff,
    output logic [DATA_W-1:0]                 rdat
);
    localparam int SEC_W = $clog2(SEC_PER_PU);
    localparam int DEPTH = NUM_PU * SEC_PER_PU;

    logic [SEC_W-1:0]  off_mem [DEPTH];
    logic [DATA_W-1:0] dat_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            off_mem[waddr] <= woff;
            dat_mem[waddr] <= wdat;
        end
    end

    assign roff = off_mem[raddr];
    assign rdat = dat_mem[raddr];

    AST_WADDR_KNOWN: assert property (@(posedge clk) we |-> !$isunknown(waddr)); // R3

endmodule

// File: rtl/seqapp_vu_table.sv
// Per-virtual-unit chain of physical units, chain length and append pointer.
module seqapp_vu_table #(
    parameter int NUM_VU     = 4,
    parameter int NUM_PU     = 8,
    parameter int SEC_PER_PU = 4,
    parameter int MAX_CHAIN  = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [$clog2(NUM_VU)-1:0]          sel_vu,
    input  logic [$clog2(MAX_CHAIN)-1:0]       pos,
    input  logic                               upd_en,
    input  logic                               upd_link,
    input  logic [$clog2(NUM_PU)-1:0]          new_pu,
    output logic [$clog2(MAX_CHAIN+1)-1:0]     len_o,
    output logic [$clog2(SEC_PER_PU)-1:0]      ptr_o,
    output logic [$clog2(NUM_PU)-1:0]          pu_o
);
    localparam int PU_W  = $clog2(NUM_PU);
    localparam int SEC_W = $clog2(SEC_PER_PU);
    localparam int LEN_W = $clog2(MAX_CHAIN + 1);
    localparam int CH_W  = $clog2(MAX_CHAIN);

    logic [LEN_W-1:0] len_q   [NUM_VU];
    logic [SEC_W-1:0] ptr_q   [NUM_VU];
    logic [PU_W-1:0]  chain_q [NUM_VU][MAX_CHAIN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VU; v++) begin
                len_q[v] <= '0;
                ptr_q[v] <= '0;
                for (int c = 0; c < MAX_CHAIN; c++) chain_q[v][c] <= '0;
            end
        end else if (upd_en) begin
            ptr_q[sel_vu] <= ptr_q[sel_vu] + 1'b1;
            if (upd_link) begin
                chain_q[sel_vu][len_q[sel_vu][CH_W-1:0]] <= new_pu;
                len_q[sel_vu] <= len_q[sel_vu] + 1'b1;
            end
        end
    end

    assign len_o = len_q[sel_vu];
    assign ptr_o = ptr_q[sel_vu];
    assign pu_o  = chain_q[sel_vu][pos];

    AST_LINK_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        upd_link |-> (len_o < LEN_W'(MAX_CHAIN))); // R6
    AST_LINK_AT_SECTOR0: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_link) |-> (ptr_o == '0)); // R2
    AST_LINK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_link |-> upd_en); // R4

endmodule

// File: rtl/seqapp_xlate.sv
module seqapp_xlate #(
    parameter int NUM_VU     = 4,
    parameter int NUM_PU     = 8,
    parameter int SEC_PER_PU = 4,   // power of two
    parameter int MAX_CHAIN  = 2,   // power of two, at least 2
    parameter int DATA_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [$clog2(NUM_VU)-1:0]     req_vu,
    input  logic [$clog2(SEC_PER_PU)-1:0] req_off,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          ready,
    input  logic                          alloc_valid,
    input  logic [$clog2(NUM_PU)-1:0]     alloc_unit,
    output logic                          alloc_take,
    output logic                          rsp_valid,
    output logic [1:0]                    rsp_status,
    output logic [$clog2(NUM_PU)-1:0]     rsp_pu,
    output logic [$clog2(SEC_PER_PU)-1:0] rsp_sec,
    output logic [DATA_W-1:0]             rsp_rdata
);
    import seqapp_pkg::*;

    localparam int VU_W  = $clog2(NUM_VU);
    localparam int PU_W  = $clog2(NUM_PU);
    localparam int SEC_W = $clog2(SEC_PER_PU);
    localparam int LEN_W = $clog2(MAX_CHAIN + 1);
    localparam int CH_W  = $clog2(MAX_CHAIN);
    localparam int IDX_W = CH_W + SEC_W;
    localparam int CNT_W = $clog2(MAX_CHAIN * SEC_PER_PU + 1);

    state_e state_q, state_d;

    logic              wr_q;
    logic [VU_W-1:0]   vu_q;
    logic [SEC_W-1:0]  off_q;
    logic [DATA_W-1:0] wdat_q;
    logic [IDX_W-1:0]  idx_q;
    logic              empty_q;

    logic [VU_W-1:0]   sel_vu;
    logic [CH_W-1:0]   pos;
    logic [LEN_W-1:0]  len_sel;
    logic [SEC_W-1:0]  ptr_sel;
    logic [PU_W-1:0]   pu_at_pos;
    logic [CNT_W-1:0]  fill_cnt;
    logic              need_new, can_write, upd_en, upd_link, mem_we;
    logic [PU_W-1:0]   w_pu;
    logic [SEC_W-1:0]  mem_off;
    logic [DATA_W-1:0] mem_dat;
    logic              match, scan_last;

    assign sel_vu = (state_q == ST_IDLE) ? req_vu : vu_q;
    assign pos    = (state_q == ST_SCAN) ? idx_q[IDX_W-1:SEC_W]
                                         : CH_W'(len_sel - 1'b1);

    seqapp_vu_table #(
        .NUM_VU(NUM_VU), .NUM_PU(NUM_PU),
        .SEC_PER_PU(SEC_PER_PU), .MAX_CHAIN(MAX_CHAIN)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .sel_vu(sel_vu), .pos(pos),
        .upd_en(upd_en), .upd_link(upd_link), .new_pu(alloc_unit),
        .len_o(len_sel), .ptr_o(ptr_sel), .pu_o(pu_at_pos)
    );

    // Sectors already written in the selected chain.
    always_comb begin
        if (len_sel == '0)
            fill_cnt = '0;
        else if (ptr_sel == '0)
            fill_cnt = CNT_W'(len_sel) << SEC_W;
        else
            fill_cnt = (CNT_W'(len_sel - 1'b1) << SEC_W) | CNT_W'(ptr_sel);
    end

    assign need_new  = (ptr_sel == '0);
    assign can_write = need_new ? (alloc_valid && (len_sel < LEN_W'(MAX_CHAIN))) : 1'b1;
    assign upd_en    = (state_q == ST_WRITE) && can_write;
    assign upd_link  = upd_en && need_new;
    assign mem_we    = upd_en;
    assign w_pu      = need_new ? alloc_unit : pu_at_pos;

    seqapp_meta_mem #(
        .NUM_PU(NUM_PU), .SEC_PER_PU(SEC_PER_PU), .DATA_W(DATA_W)
    ) u_mem (
        .clk(clk), .we(mem_we), .waddr({w_pu, ptr_sel}),
        .woff(off_q), .wdat(wdat_q),
        .raddr({pu_at_pos, idx_q[SEC_W-1:0]}),
        .roff(mem_off), .rdat(mem_dat)
    );

    assign match     = !empty_q && (mem_off == off_q);
    assign scan_last = empty_q || match || (idx_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = req_write ? ST_WRITE : ST_SCAN;
            ST_WRITE: state_d = ST_IDLE;
            ST_SCAN:  if (scan_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign ready      = (state_q == ST_IDLE);
    assign alloc_take = upd_link;

    // Outputs and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= RSP_OK;
            rsp_pu     <= '0;
            rsp_sec    <= '0;
            rsp_rdata  <= '0;
            wr_q       <= 1'b0;
            vu_q       <= '0;
            off_q      <= '0;
            wdat_q     <= '0;
            idx_q      <= '0;
            empty_q    <= 1'b1;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    wr_q    <= req_write;
                    vu_q    <= req_vu;
                    off_q   <= req_off;
                    wdat_q  <= req_wdata;
                    idx_q   <= IDX_W'(fill_cnt - 1'b1);
                    empty_q <= (fill_cnt == '0);
                end
                ST_WRITE: begin
                    rsp_valid  <= 1'b1;
                    rsp_status <= can_write ? RSP_OK : RSP_NOSPACE;
                    rsp_pu     <= can_write ? w_pu : '0;
                    rsp_sec    <= ptr_sel;
                    rsp_rdata  <= '0;
                end
                ST_SCAN: begin
                    if (scan_last) begin
                        rsp_valid  <= 1'b1;
                        rsp_status <= match ? RSP_OK : RSP_MISS;
                        rsp_pu     <= match ? pu_at_pos : '0;
                        rsp_sec    <= match ? idx_q[SEC_W-1:0] : '0;
                        rsp_rdata  <= match ? mem_dat : '0;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_TAKE_HAS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_take |-> alloc_valid); // R5
    AST_TAKE_THEN_SEC0: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_take |=> (rsp_valid && rsp_status == RSP_OK && rsp_sec == '0
                        && rsp_pu == $past(alloc_unit))); // R4
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9
    AST_NOSPACE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == RSP_NOSPACE) |-> !$past(alloc_take)); // R5
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready); // R9

endmodule

// File: tb/seqapp_xlate_bench.sv
module seqapp_xlate_bench;
    localparam int NV = 4, NP = 8, S = 4, MC = 2, DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_vu = '0, req_off = '0;
    logic [7:0] req_wdata = '0;
    logic ready, alloc_valid, alloc_take, rsp_valid;
    logic [2:0] alloc_unit, rsp_pu;
    logic [1:0] rsp_status, rsp_sec;
    logic [7:0] rsp_rdata;

    always #2 clk = ~clk;   // 250 MHz

    seqapp_xlate #(.NUM_VU(NV), .NUM_PU(NP), .SEC_PER_PU(S),
                   .MAX_CHAIN(MC), .DATA_W(DW)) u_seqapp_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_vu(req_vu), .req_off(req_off), .req_wdata(req_wdata), .ready(ready),
        .alloc_valid(alloc_valid), .alloc_unit(alloc_unit), .alloc_take(alloc_take),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_pu(rsp_pu),
        .rsp_sec(rsp_sec), .rsp_rdata(rsp_rdata)
    );

    // Free-unit allocator model: units handed out in a fixed scrambled order.
    int free_head = 0;
    int free_avail = NP;
    int take_cnt = 0;
    function automatic int unit_of(input int k);
        return (k * 5 + 3) % NP;
    endfunction
    assign alloc_valid = (free_head < free_avail);
    assign alloc_unit  = 3'(unit_of(free_head));
    always @(posedge clk) if (rst_n && alloc_take) begin
        free_head <= free_head + 1;
        take_cnt  <= take_cnt + 1;
    end

    int checks = 0, fails = 0, cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 50000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model of the chains.
    int m_len [NV];
    int m_cnt [NV];
    int m_chain [NV][MC];
    int m_off [NV][MC*S];
    int m_dat [NV][MC*S];

    int r_status, r_pu, r_sec, r_data;
    bit r_busy_ok, r_pulse_ok;

    task automatic do_req(input bit wr, input int vu, input int off, input int dat);
        int n;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vu = 2'(vu);
        req_off = 2'(off); req_wdata = 8'(dat);
        @(negedge clk);
        req_valid = 1'b0;
        r_busy_ok = !ready;
        n = 0;
        while (!rsp_valid && n < 64) begin
            @(negedge clk);
            n++;
        end
        if (n >= 64) chk(1'b0, "R9 response timeout", n, 0);
        r_status = rsp_status; r_pu = rsp_pu; r_sec = rsp_sec; r_data = rsp_rdata;
        @(negedge clk);
        r_pulse_ok = !rsp_valid;
    endtask

    task automatic op(input bit wr, input int vu, input int off, input int dat,
                      input string tag);
        int es, ep, esec, ed;
        es = 0; ep = 0; esec = 0; ed = 0;
        if (wr) begin
            if (m_cnt[vu] % S == 0) begin
                if (m_len[vu] == MC || free_head >= free_avail) es = 2;
                else begin
                    m_chain[vu][m_len[vu]] = unit_of(free_head);
                    m_len[vu]++;
                end
            end
            if (es == 0) begin
                ep = m_chain[vu][m_cnt[vu] / S];
                esec = m_cnt[vu] % S;
                m_off[vu][m_cnt[vu]] = off;
                m_dat[vu][m_cnt[vu]] = dat;
                m_cnt[vu]++;
            end
        end else begin
            es = 1;
            for (int i = m_cnt[vu] - 1; i >= 0; i--) begin
                if (es == 1 && m_off[vu][i] == off) begin
                    es = 0; ep = m_chain[vu][i / S]; esec = i % S; ed = m_dat[vu][i];
                end
            end
        end
        do_req(wr, vu, off, dat);
        chk(r_status == es, {tag, " status"}, r_status, es);
        if (es == 0) begin
            chk(r_pu == ep, {tag, " unit"}, r_pu, ep);
            chk(r_sec == esec, {tag, " sector"}, r_sec, esec);
            if (!wr) chk(r_data == ed, {tag, " data"}, r_data, ed);
        end
    endtask

    // {write, vu, off, data}
    localparam logic [12:0] VEC [12] = '{
        {1'b1, 2'd0, 2'd2, 8'hA1},
        {1'b1, 2'd0, 2'd2, 8'hA2},
        {1'b1, 2'd1, 2'd0, 8'hB0},
        {1'b0, 2'd0, 2'd2, 8'h00},
        {1'b0, 2'd0, 2'd1, 8'h00},
        {1'b1, 2'd0, 2'd0, 8'hA3},
        {1'b1, 2'd0, 2'd3, 8'hA4},
        {1'b1, 2'd0, 2'd1, 8'hA5},
        {1'b0, 2'd0, 2'd2, 8'h00},
        {1'b0, 2'd0, 2'd1, 8'h00},
        {1'b1, 2'd1, 2'd3, 8'hB1},
        {1'b0, 2'd1, 2'd0, 8'h00}
    };

    initial begin
        int t0;
        for (int v = 0; v < NV; v++) begin m_len[v] = 0; m_cnt[v] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(alloc_take == 1'b0, "R1 alloc_take", alloc_take, 0);
        op(1'b0, 3, 0, 0, "R1 R8 empty chain read");

        // Table walk: R2 placement, R3 stored offset, R7 newest copy, R8 miss
        for (int i = 0; i < 12; i++) begin
            op(VEC[i][12], int'(VEC[i][11:10]), int'(VEC[i][9:8]), int'(VEC[i][7:0]),
               VEC[i][12] ? "R2 R3 write" : "R7 R8 read");
        end
        chk(r_busy_ok, "R9 ready low while busy", 0, 1);
        chk(r_pulse_ok, "R9 single-cycle response", 0, 1);

        // R6: fill vu0 to MAX_CHAIN units, then one more write
        op(1'b1, 0, 3, 8'hC0, "R2 fill");
        op(1'b1, 0, 0, 8'hC1, "R2 fill");
        op(1'b1, 0, 2, 8'hC2, "R2 fill");
        t0 = take_cnt;
        op(1'b1, 0, 1, 8'hC3, "R6 chain at max");
        chk(take_cnt == t0, "R6 no unit taken", take_cnt, t0);
        op(1'b0, 0, 2, 0, "R7 newest after fill");

        // R5: allocator empty
        free_avail = free_head;
        t0 = take_cnt;
        op(1'b1, 2, 1, 8'hD0, "R5 allocator empty");
        chk(take_cnt == t0, "R5 no unit taken", take_cnt, t0);
        op(1'b0, 2, 1, 0, "R5 nothing written");
        free_avail = NP;

        // R4: first write after refusal extends from sector 0, one take
        t0 = take_cnt;
        op(1'b1, 2, 1, 8'hD1, "R4 chain extension");
        chk(take_cnt == t0 + 1, "R4 one unit taken", take_cnt, t0 + 1);
        op(1'b0, 2, 1, 0, "R3 read back");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule